// File: doc/BRIEF.md
# Printer Port Register Block

This block is a byte-wide, register-mapped printer port. It models the printer handshake in hardware. A host bus reads and writes three 8-bit registers, selected by a small offset: data, status and control. A rising edge of the control register's strobe bit launches the latched data byte toward a printer sink as a one-cycle valid pulse.

The acknowledge and busy handshake is not timed against real pins. It advances one step on each status read while the strobe bit is low. A level interrupt reports a pending acknowledge when interrupts are enabled.

The host drives single-cycle read or write strobes. Read data is combinational on the current offset, so the value returned by a status read is the value from before that read's handshake step.

Top module: `pport_ctrl`

## Requirements
- R1: After reset the status register reads 0xD9 (with the paper pin low), the control register reads 0x0C, the data register reads 0x00, and both `irq` and `out_valid` are low.
- R2: Offset 0 selects data, 1 selects status and 2 selects control. Reads at offsets 3 to 7 return 0xFF, and writes there change nothing.
- R3: A read at offset 0 returns `pin_in` when control bit 5 (direction) is 1. It returns the last byte written at offset 0 when that bit is 0.
- R4: A control write with bit 2 (init, active low) equal to 0 sets the status register to 0xD8.
- R5: A control write with bits 2, 3 and 0 all set clears status bit 7 (busy, active low). If control bit 0 was 0 before that write, the data byte appears on `out_byte` with `out_valid` high for exactly the one cycle after the write. A write with bit 3 clear launches nothing.
- R6: A status read while status bit 7 is 0 and control bit 0 is 0 steps the handshake. If status bit 6 (ack) is 1 it is cleared; otherwise bits 6 and 7 are both set. In any other state a status read leaves bits 6 and 7 unchanged.
- R7: A control write stores the written byte unchanged, and control reads return it.
- R8: Status bit 5 (paper out) reads as `paper_in` during a status read, and the sampled value is stored.
- R9: After each control write or status read, `irq` equals control bit 4 (interrupt enable) AND NOT status bit 6.
- R10: Writes at the status offset are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| pin_in | input | 8 | Input byte returned on data reads in input direction |
| paper_in | input | 1 | Paper-out indication |
| out_byte | output | 8 | Byte launched toward the printer sink |
| out_valid | output | 1 | One-cycle qualifier for `out_byte` |
| irq | output | 1 | Level interrupt |

## Verification
The handshake is driven through a full strobe cycle and then a run of status reads. This separates the clear-ack step, the set-both step and the idle state that follows. Strobe edges are tried with select set and with select clear, and with strobe already high, so a launch is told apart from a level-triggered or unconditional one. The data register is read in both directions, to tell the input pins from the output latch. The interrupt is observed across a status read that clears ack and one that sets it again.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int unsigned DW = 8;

  // status bit positions
  localparam int unsigned ST_BUSY_N = 7;
  localparam int unsigned ST_ACK    = 6;
  localparam int unsigned ST_PAPER  = 5;
  localparam int unsigned ST_ONLINE = 4;
  localparam int unsigned ST_ERR_N  = 3;
  localparam int unsigned ST_TMO    = 0;

  // control bit positions
  localparam int unsigned CT_DIR   = 5;
  localparam int unsigned CT_IRQEN = 4;
  localparam int unsigned CT_SEL   = 3;
  localparam int unsigned CT_INIT  = 2;
  localparam int unsigned CT_ALF   = 1;
  localparam int unsigned CT_STB   = 0;

  localparam int unsigned OFF_DATA = 0;
  localparam int unsigned OFF_STAT = 1;
  localparam int unsigned OFF_CTRL = 2;

  localparam logic [DW-1:0] STATUS_RST  = 8'hD9;
  localparam logic [DW-1:0] STATUS_INIT = 8'hD8;
  localparam logic [DW-1:0] CTRL_RST    = 8'h0C;

  // one handshake step on a status read
  function automatic logic [DW-1:0] step_status(input logic [DW-1:0] s);
    logic [DW-1:0] r;
    r = s;
    if (s[ST_ACK]) begin
      r[ST_ACK] = 1'b0;
    end else begin
      r[ST_ACK]    = 1'b1;
      r[ST_BUSY_N] = 1'b1;
    end
    return r;
  endfunction

  // status effect of a control write
  function automatic logic [DW-1:0] status_on_ctrl(input logic [DW-1:0] s,
                                                   input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = s;
    if (!w[CT_INIT]) r = STATUS_INIT;
    else if (w[CT_SEL] && w[CT_STB]) r[ST_BUSY_N] = 1'b0;
    return r;
  endfunction

  function automatic logic irq_level(input logic [DW-1:0] c, input logic [DW-1:0] s);
    return c[CT_IRQEN] && !s[ST_ACK];
  endfunction
endpackage

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] data_q,
  output logic          launch,
  output logic [DW-1:0] out_byte,
  output logic          out_valid
);
  assign launch = ctrl_wr && wdata[CT_INIT] && wdata[CT_SEL] && wdata[CT_STB]
                  && !ctrl_q[CT_STB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      data_q    <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (data_wr) data_q <= wdata;
      out_valid <= launch;
      if (launch) out_byte <= data_q;
    end
  end

  assert_ctrl_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata));
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

// File: rtl/pport_status.sv
module pport_status
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          stat_rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ctrl_q,
  input  logic          paper_in,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] status_next,
  output logic          step_evt
);
  logic [DW-1:0] sampled;

  assign step_evt = stat_rd && !status_q[ST_BUSY_N] && !ctrl_q[CT_STB];

  always_comb begin
    sampled = status_q;
    sampled[ST_PAPER] = paper_in;
    status_next = status_q;
    if (ctrl_wr)       status_next = status_on_ctrl(status_q, wdata);
    else if (step_evt) status_next = step_status(sampled);
    else if (stat_rd)  status_next = sampled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STATUS_RST;
    else        status_q <= status_next;
  end

  assert_init_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CT_INIT]) |=> status_q == STATUS_INIT);
  assert_step_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !status_q[ST_ACK]) |=> (status_q[ST_ACK] && status_q[ST_BUSY_N]));
  assert_step_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && status_q[ST_ACK]) |=> !status_q[ST_ACK]);
endmodule

// File: rtl/pport_irq.sv
module pport_irq
  import pport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          stat_rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ctrl_q,
  input  logic [DW-1:0] status_next,
  output logic          irq
);
  logic [DW-1:0] ctrl_next;
  logic          reeval;

  assign ctrl_next = ctrl_wr ? wdata : ctrl_q;
  assign reeval    = ctrl_wr || stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq <= 1'b0;
    else if (reeval) irq <= irq_level(ctrl_next, status_next);
  end

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reeval |=> $stable(irq));
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter logic [7:0]  RD_FILL = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [7:0]    pin_in,
  input  logic          paper_in,
  output logic [7:0]    out_byte,
  output logic          out_valid,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);

  logic          ctrl_wr, data_wr, stat_rd;
  logic [DW-1:0] ctrl_q, data_q, status_q, status_next;
  logic          launch, step_evt;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  pport_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .data_q(data_q), .launch(launch),
    .out_byte(out_byte), .out_valid(out_valid)
  );

  pport_status u_status (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .paper_in(paper_in),
    .status_q(status_q), .status_next(status_next), .step_evt(step_evt)
  );

  pport_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .status_next(status_next), .irq(irq)
  );

  always_comb begin
    bus_rdata = RD_FILL;
    unique case (bus_addr)
      A_DATA:  bus_rdata = ctrl_q[CT_DIR] ? pin_in : data_q;
      A_STAT: begin
        bus_rdata = status_q;
        bus_rdata[ST_PAPER] = paper_in;
      end
      A_CTRL:  bus_rdata = ctrl_q;
      default: bus_rdata = RD_FILL;
    endcase
  end

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr || stat_rd) |=> irq == (ctrl_q[CT_IRQEN] && !status_q[ST_ACK]));
  assert_launch_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (out_valid && out_byte == $past(data_q)));
  assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !status_q[ST_BUSY_N]);
  assert_step_only_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> stat_rd);
endmodule

// File: tb/pport_ctrl_tb.sv
module pport_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hA5;
  logic       paper_in = 1'b0;
  logic [7:0] out_byte;
  logic       out_valid, irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pport_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .paper_in(paper_in), .out_byte(out_byte),
    .out_valid(out_valid), .irq(irq)
  );

  // {is_read, addr[2:0], wdata[7:0], expected[7:0]}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd2, 8'h00, 8'h0C},  // R1 control reset
    {1'b1, 3'd1, 8'h00, 8'hD9},  // R1 status reset
    {1'b1, 3'd0, 8'h00, 8'h00},  // R1 data reset
    {1'b0, 3'd0, 8'h41, 8'h00},  // write data
    {1'b1, 3'd0, 8'h00, 8'h41},  // R3 output latch
    {1'b0, 3'd2, 8'h2C, 8'h00},  // direction = input
    {1'b1, 3'd0, 8'h00, 8'hA5},  // R3 input pins
    {1'b1, 3'd2, 8'h00, 8'h2C},  // R7 readback
    {1'b0, 3'd2, 8'h0C, 8'h00},
    {1'b0, 3'd2, 8'h0D, 8'h00},  // R5 strobe edge, busy clears
    {1'b0, 3'd2, 8'h0C, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h59},  // R6 read then ack clears
    {1'b1, 3'd1, 8'h00, 8'h19},  // R6 read then ack+busy set
    {1'b1, 3'd1, 8'h00, 8'hD9},  // R6 idle
    {1'b0, 3'd1, 8'h00, 8'h00},  // R10 status write
    {1'b1, 3'd1, 8'h00, 8'hD9},  // R10 unchanged
    {1'b1, 3'd5, 8'h00, 8'hFF},  // R2 unmapped read
    {1'b0, 3'd2, 8'h08, 8'h00},  // R4 init low
    {1'b1, 3'd1, 8'h00, 8'hD8},  // R4 forced status
    {1'b1, 3'd2, 8'h00, 8'h08}   // R7 readback
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(bus_rdata, exp, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({7'd0, irq}, 8'h00, "R1 irq");
    check({7'd0, out_valid}, 8'h00, "R1 out_valid");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) rd(VEC[i][18:16], VEC[i][7:0], $sformatf("vector %0d", i));
      else            wr(VEC[i][18:16], VEC[i][15:8]);
    end
    // R8 paper pin sampled on status read
    paper_in = 1'b1;
    rd(3'd1, 8'hF8, "R8 paper high");
    paper_in = 1'b0;
    rd(3'd1, 8'hD8, "R8 paper low");
    // R2 unmapped write has no effect
    wr(3'd6, 8'h00);
    rd(3'd2, 8'h08, "R2 ctrl after unmapped write");
    // R5 launch on strobe rising edge
    wr(3'd0, 8'h3C);
    wr(3'd2, 8'h0C);
    wr(3'd2, 8'h0D);
    check({7'd0, out_valid}, 8'h01, "R5 valid after edge");
    check(out_byte, 8'h3C, "R5 byte");
    @(negedge clk);
    check({7'd0, out_valid}, 8'h00, "R5 single cycle");
    wr(3'd2, 8'h0D);
    check({7'd0, out_valid}, 8'h00, "R5 no relaunch at strobe high");
    rd(3'd1, 8'h58, "R5 busy cleared");
    wr(3'd2, 8'h0C);
    wr(3'd2, 8'h05);
    check({7'd0, out_valid}, 8'h00, "R5 no launch with select clear");
    // R9 interrupt tracks enable and ack
    wr(3'd2, 8'h1C);
    check({7'd0, irq}, 8'h00, "R9 ack set");
    rd(3'd1, 8'h58, "R6 step read");
    check({7'd0, irq}, 8'h01, "R9 ack cleared");
    rd(3'd1, 8'h18, "R6 second step");
    check({7'd0, irq}, 8'h00, "R9 ack set again");
    wr(3'd2, 8'h0C);
    check({7'd0, irq}, 8'h00, "R9 disabled");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule